// File: doc/BRIEF.md
# Serial Register-Access Slave for a Measurement Converter

This block is the target side of a serial port on a slow measurement converter. The port has four pins: an active-low select, a serial clock, a data input, and one output that carries shifted data and, when it is not shifting, the converter's data-ready condition. A fast system clock oversamples the three input pins. Each access starts with an 8-bit command byte, sent MSB first. The command picks a register and a direction. The register is then written or read MSB first, and the port goes back to waiting for the next command.

The register file sits next to the port as parallel state. It holds the mode byte, the input-channel selection, the latest conversion word, and the ready and error flags that build the status byte. The converter delivers each word on a one-cycle strobe. A continuous-read mode sends each fresh word out on the serial clock with no command. Holding the data input at one for 32 serial clocks forces the whole block back to its power-on state. The output is modelled as a data bit plus an output-enable.

The control state machine has four states. `ST_CMD` collects a command byte. `ST_WR` shifts in a byte to be written. `ST_RD` shifts out a register. `ST_CRD` streams conversion words. The transitions are as follows:
- CMD→WR on a write command to the mode or reserved register.
- CMD→RD on any read command without the continuous bit.
- CMD→CRD on the enter-stream command.
- WR→CMD after 8 bits.
- RD→CMD after the last bit of the register.
- CRD→CMD at the end of a streamed word that carried the exit command.
- Any state→CMD on a 32-ones reset.
Raising select holds the current state.

Top module: `serial_reg_port`

## Requirements
- R1: After reset the output-enable is low while select is high. A status read (command 0x08) returns 0x8C, a mode read (command 0x18) returns 0x02, and a data read (command 0x38) returns 0. The mode output is 0x02 and the channel output is 0.
- R2: In command state, a 1 arriving as the first bit of a byte is dropped, and bit collection stays at the first position. A command preceded by any number of ones (fewer than 32) still executes.
- R3: A command byte with bit 6 set is discarded entirely, so the byte after it is taken as a new command.
- R4: Command 0x10 followed by byte V sets the mode register to V, for every V, and command 0x18 reads back V MSB first.
- R5: Command byte bits 5:4 select the register: 00 is status, 01 is mode, 10 is reserved, 11 is data. Bit 3 selects read (1), bits 1:0 are the channel, and every accepted command loads the channel. The status byte is {not_ready, error, 0, 0, 1, wide(1 for a 24-bit word), channel}, and it shows the channel of the command that reads it.
- R6: A conversion strobe loads the data word and clears not_ready. A completed data read sets not_ready. The word can be read again with the same value until the next strobe.
- R7: While select is low and no register is being shifted out, the data output equals not_ready. A completed mode write sets not_ready and clears the error flag.
- R8: 32 consecutive ones on the data input (sampled on serial-clock rises with select low) return every register to its reset value and the interface to command state. 31 ones followed by a zero do not.
- R9: Raising select mid-byte discards the partial bits. Whether a command or a register byte is expected next is kept.
- R10: Command 0x3C enters continuous read. Each new word streams out on the next 24 clocks and is sent only once. Clocks while not_ready is 1 shift nothing, and the output stays 1.
- R11: In continuous read, a byte 0011_10xx in the first 8 input bits of a streamed word exits to command state at the end of that word. Sending it while not_ready is 1 has no effect.
- R12: A write command to the data register (0x30) is dropped and the interface stays in command state. A write to the reserved register is discarded, and a read of it (0x28) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts the byte in progress |
| sclk | input | 1 | Serial clock; idles high, input sampled on rise |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data out, or not_ready when not shifting |
| sdo_oe | output | 1 | Output enable for sdo (high while select is low) |
| cnv_strobe | input | 1 | One-cycle pulse: a new conversion word is ready |
| cnv_word | input | DW | Conversion result captured on the strobe |
| cnv_err | input | 1 | Clamped-result flag captured with the word |
| mode_q | output | 8 | Current mode register contents |
| chan_sel | output | 2 | Current input-channel selection |

## Verification
The assertions assume the serial clock stays at one level for at least four system clocks. Without that, the synchroniser delay would merge edges. They also assume select changes only while the serial clock is high and settled, and that no conversion strobe arrives in the same cycle as a serial edge being checked. The bench holds every serial half-period at five system clocks and changes select only with several idle cycles on each side. It drives all inputs on the falling system-clock edge. It holds the data input low while reading, so that ones counted for the reset appear only where a test sends them on purpose.

// File: rtl/serial_reg_port_pkg.sv
package serial_reg_port_pkg;

    typedef enum logic [1:0] {
        ST_CMD = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2,
        ST_CRD = 2'd3
    } port_state_e;

    localparam logic [1:0] SEL_STAT = 2'b00;
    localparam logic [1:0] SEL_MODE = 2'b01;
    localparam logic [1:0] SEL_RSVD = 2'b10;
    localparam logic [1:0] SEL_DATA = 2'b11;

    localparam logic [7:0] MODE_POR = 8'h02;
    localparam logic [5:0] EXIT_PAT = 6'b001110;

endpackage

// File: rtl/port_sync.sv
module port_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ones_watch.sv
module ones_watch #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_in,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            trip  <= 1'b0;
        end else begin
            trip <= 1'b0;
            if (tick) begin
                if (!bit_in) begin
                    run_q <= '0;
                end else if (run_q == CW'(LIMIT - 1)) begin
                    run_q <= '0;
                    trip  <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    // R8: the last one of a full run fires the reset pulse
    p_trip_on_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && bit_in && run_q == CW'(LIMIT - 1)) |=> trip);

    // R8: a zero never fires it
    p_zero_no_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !bit_in) |=> !trip);
endmodule

// File: rtl/port_regfile.sv
module port_regfile
    import serial_reg_port_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          mode_we,
    input  logic [7:0]    mode_wd,
    input  logic          chan_we,
    input  logic [1:0]    chan_wd,
    input  logic          rd_done,
    input  logic          cnv_strobe,
    input  logic [DW-1:0] cnv_word,
    input  logic          cnv_err,
    output logic [7:0]    mode_q,
    output logic [1:0]    chan_q,
    output logic [DW-1:0] data_q,
    output logic [5:0]    stat_hi,
    output logic          not_ready
);
    localparam logic WIDE = (DW > 16);

    logic err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_POR;
            chan_q    <= '0;
            data_q    <= '0;
            err_q     <= 1'b0;
            not_ready <= 1'b1;
        end else if (soft_rst) begin
            mode_q    <= MODE_POR;
            chan_q    <= '0;
            data_q    <= '0;
            err_q     <= 1'b0;
            not_ready <= 1'b1;
        end else begin
            if (chan_we) chan_q <= chan_wd;
            if (mode_we) begin
                mode_q    <= mode_wd;
                err_q     <= 1'b0;
                not_ready <= 1'b1;
            end else if (cnv_strobe) begin
                data_q    <= cnv_word;
                err_q     <= cnv_err;
                not_ready <= 1'b0;
            end else if (rd_done) begin
                not_ready <= 1'b1;
            end
        end
    end

    assign stat_hi = {not_ready, err_q, 2'b00, 1'b1, WIDE};

    // R6: a completed data read marks the word consumed
    p_read_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !soft_rst && !mode_we && !cnv_strobe) |=> not_ready);

    // R6: a fresh word clears the flag
    p_strobe_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_strobe && !soft_rst && !mode_we) |=> (!not_ready && data_q == $past(cnv_word)));

    // R7: a mode write sets the flag and clears the error
    p_mode_wr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !soft_rst) |=> (not_ready && !err_q));

    // R8: the serial reset restores power-on contents
    p_soft_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_q == MODE_POR && data_q == '0 && chan_q == 2'b00 && not_ready));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import serial_reg_port_pkg::*;
#(
    parameter int DW          = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ONES_LIMIT  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    output logic          sdo,
    output logic          sdo_oe,
    input  logic          cnv_strobe,
    input  logic [DW-1:0] cnv_word,
    input  logic          cnv_err,
    output logic [7:0]    mode_q,
    output logic [1:0]    chan_sel
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BYTE = CW'(7);
    localparam logic [CW-1:0] LAST_WORD = CW'(DW - 1);

    // ---------------- pin synchronisation and edges ----------------
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, sdi_s, sclk_d;
    logic       sclk_rise, sclk_fall, soft_rst;

    port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({cs_n, sclk, sdi}),
        .q   (pins_s)
    );
    assign {cs_s, sclk_s, sdi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    ones_watch #(.LIMIT(ONES_LIMIT)) u_ones (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sclk_rise & ~cs_s),
        .bit_in (sdi_s),
        .trip   (soft_rst)
    );

    // ---------------- register file ----------------
    logic          mode_we, chan_we, rd_done, not_ready;
    logic [7:0]    mode_wd;
    logic [1:0]    chan_wd;
    logic [DW-1:0] data_q;
    logic [5:0]    stat_hi;

    port_regfile #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .mode_we    (mode_we),
        .mode_wd    (mode_wd),
        .chan_we    (chan_we),
        .chan_wd    (chan_wd),
        .rd_done    (rd_done),
        .cnv_strobe (cnv_strobe),
        .cnv_word   (cnv_word),
        .cnv_err    (cnv_err),
        .mode_q     (mode_q),
        .chan_q     (chan_sel),
        .data_q     (data_q),
        .stat_hi    (stat_hi),
        .not_ready  (not_ready)
    );

    // ---------------- control state ----------------
    port_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] rd_last_q, rd_last_d;
    logic [6:0]    in_sh_q, in_sh_d;
    logic [DW-1:0] out_sh_q, out_sh_d;
    logic          sdo_q, sdo_d;
    logic          frame_q, frame_d;
    logic          exit_q, exit_d;
    logic          rd_data_q, rd_data_d;
    logic          wr_mode_q, wr_mode_d;
    logic [7:0]    cb;

    assign cb = {in_sh_q, sdi_s};

    function automatic logic [DW-1:0] align8(input logic [7:0] v);
        return {v, {(DW-8){1'b0}}};
    endfunction

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        rd_last_d = rd_last_q;
        in_sh_d   = in_sh_q;
        out_sh_d  = out_sh_q;
        sdo_d     = sdo_q;
        frame_d   = frame_q;
        exit_d    = exit_q;
        rd_data_d = rd_data_q;
        wr_mode_d = wr_mode_q;
        mode_we   = 1'b0;
        mode_wd   = cb;
        chan_we   = 1'b0;
        chan_wd   = cb[1:0];
        rd_done   = 1'b0;

        if (cs_s) begin
            cnt_d   = '0;
            frame_d = 1'b0;
            exit_d  = 1'b0;
        end else if (sclk_fall) begin
            if (state_q == ST_RD || (state_q == ST_CRD && frame_q)) begin
                sdo_d    = out_sh_q[DW-1];
                out_sh_d = out_sh_q << 1;
            end else if (state_q == ST_CRD && !not_ready) begin
                sdo_d    = data_q[DW-1];
                out_sh_d = data_q << 1;
                frame_d  = 1'b1;
                exit_d   = 1'b0;
                cnt_d    = '0;
            end
        end else if (sclk_rise) begin
            unique case (state_q)
                ST_CMD: begin
                    if (!(cnt_q == '0 && sdi_s)) begin
                        in_sh_d = cb[6:0];
                        if (cnt_q != LAST_BYTE) begin
                            cnt_d = cnt_q + 1'b1;
                        end else begin
                            cnt_d = '0;
                            if (!cb[6]) begin
                                chan_we = 1'b1;
                                unique case (cb[5:4])
                                    SEL_STAT: if (cb[3]) begin
                                        state_d   = ST_RD;
                                        rd_last_d = LAST_BYTE;
                                        rd_data_d = 1'b0;
                                        out_sh_d  = align8({stat_hi, cb[1:0]});
                                    end
                                    SEL_MODE: begin
                                        if (cb[3]) begin
                                            state_d   = ST_RD;
                                            rd_last_d = LAST_BYTE;
                                            rd_data_d = 1'b0;
                                            out_sh_d  = align8(mode_q);
                                        end else begin
                                            state_d   = ST_WR;
                                            wr_mode_d = 1'b1;
                                        end
                                    end
                                    SEL_RSVD: begin
                                        if (cb[3]) begin
                                            state_d   = ST_RD;
                                            rd_last_d = LAST_BYTE;
                                            rd_data_d = 1'b0;
                                            out_sh_d  = '0;
                                        end else begin
                                            state_d   = ST_WR;
                                            wr_mode_d = 1'b0;
                                        end
                                    end
                                    SEL_DATA: begin
                                        if (cb[3] && cb[2]) begin
                                            state_d = ST_CRD;
                                            frame_d = 1'b0;
                                        end else if (cb[3]) begin
                                            state_d   = ST_RD;
                                            rd_last_d = LAST_WORD;
                                            rd_data_d = 1'b1;
                                            out_sh_d  = data_q;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                end
                ST_WR: begin
                    in_sh_d = cb[6:0];
                    if (cnt_q != LAST_BYTE) begin
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        cnt_d   = '0;
                        state_d = ST_CMD;
                        mode_we = wr_mode_q;
                    end
                end
                ST_RD: begin
                    if (cnt_q != rd_last_q) begin
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        cnt_d   = '0;
                        state_d = ST_CMD;
                        rd_done = rd_data_q;
                    end
                end
                ST_CRD: begin
                    if (frame_q) begin
                        in_sh_d = cb[6:0];
                        if (cnt_q == LAST_BYTE && cb[7:2] == EXIT_PAT) exit_d = 1'b1;
                        if (cnt_q != LAST_WORD) begin
                            cnt_d = cnt_q + 1'b1;
                        end else begin
                            cnt_d   = '0;
                            frame_d = 1'b0;
                            rd_done = 1'b1;
                            if (exit_q) state_d = ST_CMD;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
        end else if (soft_rst) begin
            state_q <= ST_CMD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rd_last_q <= LAST_BYTE;
            in_sh_q   <= '0;
            out_sh_q  <= '0;
            sdo_q     <= 1'b1;
            frame_q   <= 1'b0;
            exit_q    <= 1'b0;
            rd_data_q <= 1'b0;
            wr_mode_q <= 1'b0;
        end else if (soft_rst) begin
            cnt_q     <= '0;
            rd_last_q <= LAST_BYTE;
            in_sh_q   <= '0;
            out_sh_q  <= '0;
            sdo_q     <= 1'b1;
            frame_q   <= 1'b0;
            exit_q    <= 1'b0;
            rd_data_q <= 1'b0;
            wr_mode_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            rd_last_q <= rd_last_d;
            in_sh_q   <= in_sh_d;
            out_sh_q  <= out_sh_d;
            sdo_q     <= sdo_d;
            frame_q   <= frame_d;
            exit_q    <= exit_d;
            rd_data_q <= rd_data_d;
            wr_mode_q <= wr_mode_d;
        end
    end

    // ---------------- pin outputs ----------------
    logic shifting;
    always_comb begin
        shifting = (state_q == ST_RD) || (state_q == ST_CRD && frame_q);
        sdo      = shifting ? sdo_q : not_ready;
        sdo_oe   = ~cs_n;
    end

    // R2: a leading one leaves collection at the first bit
    p_lead_one_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && cnt_q == '0 && sclk_rise && sdi_s && !cs_s && !soft_rst)
        |=> (cnt_q == '0 && state_q == ST_CMD));

    // R9: select high drops the partial byte
    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !soft_rst) |=> (cnt_q == '0 && !frame_q));

    // R9: select high keeps the expectation state
    p_abort_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !soft_rst) |=> state_q == $past(state_q));

    // R11: no exit from streaming while no fresh word is pending
    p_stream_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CRD && not_ready && !frame_q && !soft_rst) |=> state_q == ST_CRD);

    // R10: a falling clock with a fresh word opens a streamed frame
    p_frame_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CRD && sclk_fall && !cs_s && !frame_q && !not_ready && !soft_rst)
        |=> frame_q);
endmodule

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int DW         = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic          sdi = 1'b0;
    logic          sdo, sdo_oe;
    logic          cnv_strobe = 1'b0;
    logic [DW-1:0] cnv_word = '0;
    logic          cnv_err = 1'b0;
    logic [7:0]    mode_q;
    logic [1:0]    chan_sel;

    int checks = 0;
    int errors = 0;

    serial_reg_port #(.DW(DW)) dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .sdo (sdo), .sdo_oe (sdo_oe), .cnv_strobe (cnv_strobe),
        .cnv_word (cnv_word), .cnv_err (cnv_err), .mode_q (mode_q),
        .chan_sel (chan_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel;
        cs_n = 1'b0; idle(6);
    endtask

    task automatic desel;
        idle(2); cs_n = 1'b1; sdi = 1'b0; idle(6);
    endtask

    task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = din[i];
            sclk = 1'b0;
            idle(HALF);
            dout = {dout[30:0], sdo};
            sclk = 1'b1;
            idle(HALF);
        end
        sdi = 1'b0;
    endtask

    task automatic send(input int n, input logic [31:0] din);
        logic [31:0] dummy;
        xfer(n, din, dummy);
    endtask

    task automatic rd_reg(input logic [7:0] cmd, input int n, output logic [31:0] v);
        sel; send(8, {24'h0, cmd}); xfer(n, 32'h0, v); desel;
    endtask

    task automatic wr_mode(input logic [7:0] v);
        sel; send(8, 32'h10); send(8, {24'h0, v}); desel;
    endtask

    task automatic convert(input logic [DW-1:0] w, input logic e);
        cnv_word = w; cnv_err = e; cnv_strobe = 1'b1;
        @(negedge clk);
        cnv_strobe = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [DW-1:0] w;
        idle(3);
        rst_n = 1'b1;
        idle(4);

        // R1: reset state
        chk("R1 oe while deselected", {31'h0, sdo_oe}, 32'h0);
        chk("R1 mode port", {24'h0, mode_q}, 32'h02);
        chk("R1 channel port", {30'h0, chan_sel}, 32'h0);
        rd_reg(8'h08, 8, v);  chk("R1 status", v, 32'h8C);
        rd_reg(8'h18, 8, v);  chk("R1 mode", v, 32'h02);
        rd_reg(8'h38, 24, v); chk("R1 data", v, 32'h0);
        sel; chk("R1 oe while selected", {31'h0, sdo_oe}, 32'h1); desel;

        // R2: leading ones before a command
        sel; send(5, 32'h1F); send(8, 32'h18); xfer(8, 32'h0, v); desel;
        chk("R2 leading ones", v, 32'h02);

        // R3: bit 6 set rejects the byte; next byte is a command
        sel; send(8, 32'h50); send(8, 32'h18); xfer(8, 32'h0, v); desel;
        chk("R3 bit6 reject", v, 32'h02);

        // R4: full sweep of the mode register
        for (int m = 0; m < 256; m++) begin
            wr_mode(8'(m));
            chk("R4 mode port", {24'h0, mode_q}, 32'(m));
            rd_reg(8'h18, 8, v);
            chk("R4 mode readback", v, 32'(m));
        end
        wr_mode(8'h02);

        // R5: status format and channel field
        sel; send(8, 32'h03); desel;
        chk("R5 channel load", {30'h0, chan_sel}, 32'h3);
        convert(24'h00ABCD, 1'b1);
        rd_reg(8'h0B, 8, v);
        chk("R5 status fields", v, 32'h4F);
        chk("R5 channel after read", {30'h0, chan_sel}, 32'h3);

        // R6: data reads over walking-one patterns, repeatable read
        for (int b = 0; b < DW; b++) begin
            w = DW'(1) << b;
            convert(w, 1'b0);
            rd_reg(8'h38, 24, v);
            chk("R6 data word", v, {8'h0, w});
        end
        convert(24'hA5C3E1, 1'b0);
        rd_reg(8'h38, 24, v); chk("R6 first read", v, 32'hA5C3E1);
        rd_reg(8'h08, 8, v);  chk("R6 flag after read", v, 32'h8C);
        rd_reg(8'h38, 24, v); chk("R6 re-read", v, 32'hA5C3E1);

        // R7: ready shown on sdo, mode write sets flag and clears error
        convert(24'h000001, 1'b1);
        sel;
        chk("R7 sdo ready low", {31'h0, sdo}, 32'h0);
        send(8, 32'h10); send(8, 32'h02);
        idle(2);
        chk("R7 sdo after mode write", {31'h0, sdo}, 32'h1);
        desel;
        rd_reg(8'h08, 8, v); chk("R7 error cleared", v, 32'h8C);

        // R12: data write dropped, reserved write discarded, reserved read zero
        sel; send(8, 32'h30); send(8, 32'h18); xfer(8, 32'h0, v); desel;
        chk("R12 data write dropped", v, 32'h02);
        sel; send(8, 32'h20); send(8, 32'hAA); send(8, 32'h18); xfer(8, 32'h0, v); desel;
        chk("R12 reserved write discarded", v, 32'h02);
        rd_reg(8'h28, 8, v); chk("R12 reserved read", v, 32'h0);
        rd_reg(8'h38, 24, v); chk("R12 data kept", v, 32'h000001);

        // R9: abort mid command byte, then mid register byte
        sel; send(4, 32'h1); desel;
        rd_reg(8'h18, 8, v); chk("R9 partial command dropped", v, 32'h02);
        sel; send(8, 32'h10); send(4, 32'hA); desel;
        sel; send(8, 32'h5A); desel;
        chk("R9 state kept across abort", {24'h0, mode_q}, 32'h5A);

        // R8: 31 ones do not reset, 32 do
        wr_mode(8'h42);
        convert(24'h123456, 1'b0);
        sel; send(31, 32'h7FFFFFFF); send(8, 32'h18); xfer(8, 32'h0, v); desel;
        chk("R8 31 ones no reset", v, 32'h42);
        sel; send(32, 32'hFFFFFFFF); desel;
        chk("R8 mode port after reset", {24'h0, mode_q}, 32'h02);
        rd_reg(8'h08, 8, v);  chk("R8 status after reset", v, 32'h8C);
        rd_reg(8'h38, 24, v); chk("R8 data after reset", v, 32'h0);

        // R10: continuous read streams each word once
        sel; send(8, 32'h3C);
        convert(24'h3C5A96, 1'b0);
        xfer(24, 32'h0, v); chk("R10 first streamed word", v, 32'h3C5A96);
        idle(2);
        chk("R10 sdo after word", {31'h0, sdo}, 32'h1);
        xfer(8, 32'h0, v); chk("R10 no repeat of word", v, 32'hFF);
        // R11: exit command while not ready is ignored
        send(8, 32'h38);
        convert(24'hC0FFEE, 1'b0);
        xfer(24, 32'h0, v); chk("R11 still streaming", v, 32'hC0FFEE);
        // R11: exit command inside a fresh word
        convert(24'h0F1E2D, 1'b0);
        xfer(24, 32'h380000, v); chk("R11 word during exit", v, 32'h0F1E2D);
        send(8, 32'h18); xfer(8, 32'h0, v);
        chk("R11 back in command state", v, 32'h02);
        desel;

        // R8: 32 ones also reset from continuous read
        wr_mode(8'h42);
        sel; send(8, 32'h3C); send(32, 32'hFFFFFFFF); desel;
        rd_reg(8'h18, 8, v); chk("R8 reset from stream mode", v, 32'h02);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule